// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller decides which of five operating modes a processor runs in and drives the clock, PLL and supply controls that realise each mode. Software asks for a mode with a one-cycle request; moves between the two running modes (full speed through the PLL, or PLL bypassed at the input clock) pass through a relock phase in which both clocks are gated until the PLL reports lock. Requests for the three low-power modes wait for the core's idle handshake before taking effect.

Each low-power mode has its own wake sources. Sleep leaves on an external event or a GPIO interrupt and goes straight back to the running mode that was in force before. Deep sleep leaves only on a GPIO interrupt or reset and relocks first. Hibernate removes the core supply. Waking from it powers the supply back up, holds the core in reset until the supply has been good for a set number of cycles, and then relocks into full speed. The PLL and the regulator are modelled only through their lock and power-good inputs.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is low and after it, the controller is in relock toward full mode: pll_en=1, pll_bypass=0, cclk_en=0, sclk_en=0, vdd_core_en=1, dma_l1_ok=0, core_rst=0, cur_mode=0, settled=0. The first clock edge with pll_lock=1 moves it to full mode.
- R2: Running modes: full (cur_mode=0) gives pll_en=1, pll_bypass=0, both clock enables 1 and dma_l1_ok=1. Active (cur_mode=1) gives the same with pll_bypass=1. settled=1 in both.
- R3: A request with req_mode 0 or 1 that differs from the running mode enters relock at the next edge. In relock both clock enables and dma_l1_ok are 0, pll_en=1, pll_bypass follows the target, and cur_mode shows the target. The controller leaves relock for the target at the first edge where pll_lock=1.
- R4: A request with req_mode 2 (sleep), 3 (deep sleep) or 4 (hibernate) while running becomes pending. The running outputs stay unchanged with settled=0. The controller enters the low-power mode at the first edge where core_idle=1.
- R5: Sleep (cur_mode=2): cclk_en=0, sclk_en=1, pll_en=1, pll_bypass kept from the prior mode, dma_l1_ok=0. An edge with ext_wake=1 or gpio_wake=1 returns the controller directly to the prior running mode.
- R6: Deep sleep (cur_mode=3): pll_en=0, pll_bypass=0, both clock enables 0, dma_l1_ok=0. ext_wake has no effect. gpio_wake=1 moves it to relock toward the prior running mode.
- R7: Hibernate (cur_mode=4): vdd_core_en=0, core_rst=1, all clock and PLL enables 0. Either wake input starts power-up: vdd_core_en=1, core_rst=1, cur_mode=4. After RST_CYCLES consecutive edges with vdd_good=1 (a low vdd_good restarts the count), the controller enters relock toward full mode with core_rst=0, whatever the mode was before hibernate.
- R8: A request is ignored when it names the current running mode, when req_mode is 5 to 7, or when the controller is not settled (pending, relock, low power, power-up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code (0 full, 1 active, 2 sleep, 3 deep, 4 hibernate) |
| core_idle | input | 1 | Core idle handshake |
| ext_wake | input | 1 | External wake event |
| gpio_wake | input | 1 | Asynchronous GPIO interrupt, already synchronised |
| pll_lock | input | 1 | PLL lock indication |
| vdd_good | input | 1 | Core supply power-good |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | Route input clock around the PLL |
| cclk_en | output | 1 | Core clock gate enable |
| sclk_en | output | 1 | System clock gate enable |
| vdd_core_en | output | 1 | Core supply enable |
| dma_l1_ok | output | 1 | DMA to local L1 memory permitted |
| core_rst | output | 1 | Core reset held during hibernate and power-up |
| cur_mode | output | 3 | Mode whose settings are applied or targeted |
| settled | output | 1 | Controller is in a running mode and accepts requests |

## Verification
The assertions take the wake, idle, lock and power-good inputs to be already synchronised to clk and stable across each edge. They make no assumption on how long lock or power-good stay low, so each exit is checked only against the previous-cycle input that allowed it. The stimulus drives every input at the falling edge. Requests, wakes, lock and power-good are drawn at random with a fixed seed, including out-of-range mode codes and requests that arrive while not settled. A bench model steps through the same transitions to give the expected value of every output in every cycle. Directed sequences also reach each mode and its wake paths, including a power-good dropout during power-up.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    MD_FULL   = 3'd0,
    MD_ACTIVE = 3'd1,
    MD_SLEEP  = 3'd2,
    MD_DEEP   = 3'd3,
    MD_HIBER  = 3'd4
  } pmode_e;

  typedef enum logic [2:0] {
    ST_RUN, ST_RELOCK, ST_PEND, ST_SLEEP, ST_DEEP, ST_HIBER, ST_PWRUP
  } pstate_e;

  typedef struct packed {
    logic pll_en;
    logic pll_bypass;
    logic cclk_en;
    logic sclk_en;
    logic vdd_en;
    logic dma_ok;
    logic core_rst;
  } pctl_t;

  function automatic logic is_run_code(logic [2:0] code);
    return (code == 3'(MD_FULL)) || (code == 3'(MD_ACTIVE));
  endfunction

  function automatic logic is_lp_code(logic [2:0] code);
    return (code >= 3'(MD_SLEEP)) && (code <= 3'(MD_HIBER));
  endfunction

  function automatic logic is_lp_state(pstate_e st);
    return (st == ST_SLEEP) || (st == ST_DEEP) || (st == ST_HIBER);
  endfunction

  // Control settings applied by each controller state.
  function automatic pctl_t ctl_for(pstate_e st, pmode_e run_md);
    pctl_t c;
    logic  byp;
    byp = (run_md == MD_ACTIVE);
    c   = '0;
    unique case (st)
      ST_RUN, ST_PEND: c = '{pll_en:1'b1, pll_bypass:byp, cclk_en:1'b1, sclk_en:1'b1,
                             vdd_en:1'b1, dma_ok:1'b1, core_rst:1'b0};
      ST_RELOCK:       c = '{pll_en:1'b1, pll_bypass:byp, cclk_en:1'b0, sclk_en:1'b0,
                             vdd_en:1'b1, dma_ok:1'b0, core_rst:1'b0};
      ST_SLEEP:        c = '{pll_en:1'b1, pll_bypass:byp, cclk_en:1'b0, sclk_en:1'b1,
                             vdd_en:1'b1, dma_ok:1'b0, core_rst:1'b0};
      ST_DEEP:         c = '{pll_en:1'b0, pll_bypass:1'b0, cclk_en:1'b0, sclk_en:1'b0,
                             vdd_en:1'b1, dma_ok:1'b0, core_rst:1'b0};
      ST_HIBER:        c = '{pll_en:1'b0, pll_bypass:1'b0, cclk_en:1'b0, sclk_en:1'b0,
                             vdd_en:1'b0, dma_ok:1'b0, core_rst:1'b1};
      ST_PWRUP:        c = '{pll_en:1'b0, pll_bypass:1'b0, cclk_en:1'b0, sclk_en:1'b0,
                             vdd_en:1'b1, dma_ok:1'b0, core_rst:1'b1};
      default:         c = '0;
    endcase
    return c;
  endfunction

  // Mode code reported for each controller state.
  function automatic logic [2:0] mode_for(pstate_e st, pmode_e run_md);
    unique case (st)
      ST_SLEEP:           return 3'(MD_SLEEP);
      ST_DEEP:            return 3'(MD_DEEP);
      ST_HIBER, ST_PWRUP: return 3'(MD_HIBER);
      default:            return 3'(run_md);
    endcase
  endfunction

endpackage

// File: rtl/pms_rstseq.sv
module pms_rstseq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic vdd_good,
  output logic done
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = arm && vdd_good && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!arm || !vdd_good) cnt <= '0;
    else if (!done)            cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R7
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!vdd_good) |-> cnt == '0); // R7

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       core_idle,
  input  logic       ext_wake,
  input  logic       gpio_wake,
  input  logic       pll_lock,
  input  logic       vdd_good,
  input  logic       rst_done,
  output pstate_e    st,
  output pmode_e     run_md
);
  pstate_e st_nxt;
  pmode_e  run_nxt;
  pmode_e  lp_md, lp_nxt;

  // Named events for the assertions.
  logic req_switch, req_lowpwr, lp_enter, sleep_wake, deep_wake, hib_wake, relock_done;

  assign req_switch  = (st == ST_RUN) && req_valid && is_run_code(req_mode)
                       && (req_mode != 3'(run_md));
  assign req_lowpwr  = (st == ST_RUN) && req_valid && is_lp_code(req_mode);
  assign lp_enter    = (st == ST_PEND) && core_idle;
  assign sleep_wake  = (st == ST_SLEEP) && (ext_wake || gpio_wake);
  assign deep_wake   = (st == ST_DEEP) && gpio_wake;
  assign hib_wake    = (st == ST_HIBER) && (ext_wake || gpio_wake);
  assign relock_done = (st == ST_RELOCK) && pll_lock;

  always_comb begin
    st_nxt  = st;
    run_nxt = run_md;
    lp_nxt  = lp_md;
    unique case (st)
      ST_RUN: begin
        if (req_switch) begin
          st_nxt  = ST_RELOCK;
          run_nxt = pmode_e'(req_mode);
        end else if (req_lowpwr) begin
          st_nxt = ST_PEND;
          lp_nxt = pmode_e'(req_mode);
        end
      end
      ST_PEND: begin
        if (lp_enter) begin
          unique case (lp_md)
            MD_SLEEP: st_nxt = ST_SLEEP;
            MD_DEEP:  st_nxt = ST_DEEP;
            default:  st_nxt = ST_HIBER;
          endcase
        end
      end
      ST_RELOCK: if (relock_done) st_nxt = ST_RUN;
      ST_SLEEP:  if (sleep_wake)  st_nxt = ST_RUN;
      ST_DEEP:   if (deep_wake)   st_nxt = ST_RELOCK;
      ST_HIBER: begin
        if (hib_wake) begin
          st_nxt  = ST_PWRUP;
          run_nxt = MD_FULL;
        end
      end
      ST_PWRUP:  if (rst_done)    st_nxt = ST_RELOCK;
      default:   st_nxt = ST_RELOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RELOCK;
      run_md <= MD_FULL;
      lp_md  <= MD_SLEEP;
    end else begin
      st     <= st_nxt;
      run_md <= run_nxt;
      lp_md  <= lp_nxt;
    end
  end

  AST_RELOCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_RELOCK && st == ST_RUN) |-> $past(pll_lock)); // R3
  AST_LP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_PEND && is_lp_state(st)) |-> $past(core_idle)); // R4
  AST_SLEEP_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_SLEEP && st == ST_RUN) |-> run_md == $past(run_md)); // R5
  AST_DEEP_GPIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_DEEP && st != ST_DEEP) |-> $past(gpio_wake)); // R6
  AST_HIB_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_PWRUP && st == ST_RELOCK) |-> (run_md == MD_FULL && $past(vdd_good))); // R7
  AST_REQ_ONLY_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != ST_RUN && st == ST_RUN) |-> $past(relock_done || sleep_wake)); // R8

endmodule

// File: rtl/pms_outdec.sv
module pms_outdec
  import pms_pkg::*;
(
  input  pstate_e    st,
  input  pmode_e     run_md,
  output pctl_t      ctl,
  output logic [2:0] mode_code,
  output logic       settled
);
  assign ctl       = ctl_for(st, run_md);
  assign mode_code = mode_for(st, run_md);
  assign settled   = (st == ST_RUN);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       core_idle,
  input  logic       ext_wake,
  input  logic       gpio_wake,
  input  logic       pll_lock,
  input  logic       vdd_good,
  output logic       pll_en,
  output logic       pll_bypass,
  output logic       cclk_en,
  output logic       sclk_en,
  output logic       vdd_core_en,
  output logic       dma_l1_ok,
  output logic       core_rst,
  output logic [2:0] cur_mode,
  output logic       settled
);
  pstate_e st;
  pmode_e  run_md;
  pctl_t   ctl;
  logic    rst_done;
  logic    pwrup_arm;

  assign pwrup_arm = (st == ST_PWRUP);

  pms_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .core_idle(core_idle), .ext_wake(ext_wake), .gpio_wake(gpio_wake),
    .pll_lock(pll_lock), .vdd_good(vdd_good), .rst_done(rst_done),
    .st(st), .run_md(run_md)
  );

  pms_rstseq #(.RST_CYCLES(RST_CYCLES)) i_rstseq (
    .clk(clk), .rst_n(rst_n), .arm(pwrup_arm), .vdd_good(vdd_good), .done(rst_done)
  );

  pms_outdec i_outdec (
    .st(st), .run_md(run_md), .ctl(ctl), .mode_code(cur_mode), .settled(settled)
  );

  assign pll_en      = ctl.pll_en;
  assign pll_bypass  = ctl.pll_bypass;
  assign cclk_en     = ctl.cclk_en;
  assign sclk_en     = ctl.sclk_en;
  assign vdd_core_en = ctl.vdd_en;
  assign dma_l1_ok   = ctl.dma_ok;
  assign core_rst    = ctl.core_rst;

  AST_CLK_ON_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_en) |-> ($past(pll_lock) || $past(cur_mode) == 3'(MD_SLEEP))); // R3
  AST_SUPPLY_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_core_en |-> !(pll_en || cclk_en || sclk_en || dma_l1_ok)); // R7
  AST_SLEEP_BYPASS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'(MD_SLEEP) && $past(cur_mode) == 3'(MD_SLEEP)) |-> $stable(pll_bypass)); // R5
  AST_HIB_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_core_en) |-> $past(core_idle)); // R4

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int RCY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic core_idle = 1'b0, ext_wake = 1'b0, gpio_wake = 1'b0, pll_lock = 1'b0, vdd_good = 1'b0;
  logic pll_en, pll_bypass, cclk_en, sclk_en, vdd_core_en, dma_l1_ok, core_rst, settled;
  logic [2:0] cur_mode;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.RST_CYCLES(RCY)) i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .core_idle(core_idle), .ext_wake(ext_wake), .gpio_wake(gpio_wake),
    .pll_lock(pll_lock), .vdd_good(vdd_good), .pll_en(pll_en), .pll_bypass(pll_bypass),
    .cclk_en(cclk_en), .sclk_en(sclk_en), .vdd_core_en(vdd_core_en), .dma_l1_ok(dma_l1_ok),
    .core_rst(core_rst), .cur_mode(cur_mode), .settled(settled)
  );

  // Bench model: 0 run, 1 relock, 2 pending, 3 sleep, 4 deep, 5 hibernate, 6 power-up
  int m_st = 1, m_run = 0, m_lp = 2, m_cnt = 0;

  function automatic logic [10:0] expect_vec(int s, int r);
    logic b;
    b = (r == 1);
    case (s)
      0:       return {1'b1, b, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'(r), 1'b1};
      2:       return {1'b1, b, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'(r), 1'b0};
      1:       return {1'b1, b, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'(r), 1'b0};
      3:       return {1'b1, b, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0};
      4:       return {7'b0000100, 3'd3, 1'b0};
      5:       return {7'b0000001, 3'd4, 1'b0};
      default: return {7'b0000101, 3'd4, 1'b0};
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_st = 1; m_run = 0; m_lp = 2; m_cnt = 0;
      return;
    end
    case (m_st)
      0: if (req_valid) begin
           if (req_mode <= 3'd1 && int'(req_mode) != m_run) begin m_st = 1; m_run = int'(req_mode); end
           else if (req_mode >= 3'd2 && req_mode <= 3'd4) begin m_st = 2; m_lp = int'(req_mode); end
         end
      1: if (pll_lock) m_st = 0;
      2: if (core_idle) m_st = (m_lp == 2) ? 3 : (m_lp == 3) ? 4 : 5;
      3: if (ext_wake || gpio_wake) m_st = 0;
      4: if (gpio_wake) m_st = 1;
      5: if (ext_wake || gpio_wake) begin m_st = 6; m_run = 0; m_cnt = 0; end
      default: begin
        if (!vdd_good) m_cnt = 0;
        else if (m_cnt == RCY - 1) begin m_st = 1; m_cnt = 0; end
        else m_cnt++;
      end
    endcase
  endtask

  task automatic check(string tag);
    logic [10:0] act, exp_v;
    string t;
    act   = {pll_en, pll_bypass, cclk_en, sclk_en, vdd_core_en, dma_l1_ok, core_rst, cur_mode, settled};
    exp_v = expect_vec(m_st, m_run);
    t     = (tag == "") ? tag_of(m_st) : tag;
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s at %0t: outputs %b expected %b", t, $time, act, exp_v);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic drv(bit rv, logic [2:0] rm, bit idl, bit ew, bit gw, bit lk, bit vg);
    req_valid = rv; req_mode = rm; core_idle = idl;
    ext_wake = ew; gpio_wake = gw; pll_lock = lk; vdd_good = vg;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0a17);
    // R1: reset state, then lock release into full mode
    drv(0, 0, 0, 0, 0, 0, 0);
    repeat (2) step("R1");
    @(negedge clk); rst_n = 1'b1;
    step("R1");
    drv(0, 0, 0, 0, 0, 1, 0); step("R1");
    // R8: same-mode and out-of-range requests ignored
    drv(1, 3'd0, 0, 0, 0, 1, 0); step("R8");
    drv(1, 3'd6, 0, 0, 0, 1, 0); step("R8");
    // R3: switch to active, lock held low for two cycles
    drv(1, 3'd1, 0, 0, 0, 0, 0); step("R3");
    drv(0, 0, 0, 0, 0, 0, 0); step("R3");
    drv(0, 0, 0, 0, 0, 1, 0); step("R2");
    // R4: sleep request pending until idle; R8 request during pending ignored
    drv(1, 3'd2, 0, 0, 0, 1, 0); step("R4");
    drv(0, 0, 0, 0, 0, 1, 0); step("R4");
    drv(1, 3'd0, 0, 0, 0, 1, 0); step("R8");
    drv(0, 0, 1, 0, 0, 1, 0); step("R5");
    drv(0, 0, 0, 0, 0, 1, 0); step("R5");
    drv(0, 0, 0, 1, 0, 1, 0); step("R5");
    // R6: deep sleep, ext_wake ignored, gpio wakes through relock
    drv(1, 3'd3, 1, 0, 0, 1, 0); step("R6");
    drv(0, 0, 1, 0, 0, 1, 0); step("R6");
    drv(0, 0, 0, 1, 0, 1, 0); step("R6");
    drv(0, 0, 0, 0, 1, 0, 0); step("R6");
    drv(0, 0, 0, 0, 0, 1, 0); step("R6");
    // R7: hibernate, power-up with one power-good dropout, back to full
    drv(1, 3'd4, 0, 0, 0, 1, 0); step("R7");
    drv(0, 0, 1, 0, 0, 1, 0); step("R7");
    drv(0, 0, 0, 0, 1, 0, 1); step("R7");
    for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 0, 0, 0, 1); step("R7"); end
    drv(0, 0, 0, 0, 0, 0, 0); step("R7");
    for (int i = 0; i < RCY; i++) begin drv(0, 0, 0, 0, 0, 0, 1); step("R7"); end
    drv(0, 0, 0, 0, 0, 1, 1); step("R7");
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      drv(($urandom % 100) < 15, 3'($urandom % 8), ($urandom % 100) < 40,
          ($urandom % 100) < 5, ($urandom % 100) < 5,
          ($urandom % 100) < 75, ($urandom % 100) < 90);
      step("");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule